// File: doc/BRIEF.md
# Triggered Sample Capture Sequencer

This block controls when samples from a 10-bit ADC are written into a capture buffer. It runs in the ADC sampling clock domain. Software arms the sequencer, and it then waits for a condition on an asynchronous trigger input. The condition is chosen from two edge types and two level types. Once the condition is met, the sequencer lets a programmable number of sample clocks pass. It then writes a programmable number of consecutive samples into the buffer through a write-enable, an address that counts up, and a data word. Each data word holds the offset-binary sample with the overrange flag added above it. When the last word is written, a done flag is raised and held.

Two status outputs show the sequencer's progress. One is high while it waits for the trigger. The other is high only in the cycles where a sample is being written. The sample memory, the clock generation and the crossing to the host clock domain are outside this block.

Top module: `cap_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `armed_o`, `capturing_o`, `wr_en_o` and `done_o` are low.
- R2: A one-cycle `arm_i` pulse in the idle state raises `armed_o` in the next cycle and clears `done_o` in that same cycle. While armed and untriggered, no write occurs and `armed_o` stays high for as long as no trigger comes.
- R3: `trig_mode_i` selects the trigger condition: 2'b00 rising edge, 2'b01 falling edge, 2'b10 high level, 2'b11 low level. The trigger passes through a two-flop synchroniser plus one history flop. If the trigger input changes before clock edge k, the condition is acted on at edge k+2, and `armed_o` is low from that edge on.
- R4: With offset N taken from `offset_i`, the first write cycle (`wr_en_o` high) begins N clock edges after the trigger is acted on. N = 0 means recording starts at once.
- R5: With M taken from `total_i` (0 is treated as 1), `wr_en_o` is high for exactly M consecutive cycles. `wr_addr_o` is 0 in the first of these cycles and rises by one in each later cycle.
- R6: In each write cycle, `wr_data_o[9:0]` holds the ADC data and `wr_data_o[10]` holds the overrange flag. Both are taken from the sample registered at the clock edge that opens that cycle.
- R7: `done_o` rises in the cycle right after the last write. It stays high until an arm is accepted.
- R8: An `arm_i` pulse while the sequencer is skipping or recording is ignored. The capture finishes unchanged and the sequencer returns to idle, not to armed.
- R9: `offset_i` and `total_i` are sampled when the trigger is acted on. Later changes do not affect the capture in progress.
- R10: `capturing_o` equals the write-enable timing, and it is never high together with `armed_o`.
- R11: In an edge mode, a trigger input that already sits at the target level when the sequencer is armed does not start a capture. A fresh transition is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle arm command |
| trig_mode_i | input | 2 | Trigger condition select |
| trig_i | input | 1 | Asynchronous external trigger |
| offset_i | input | CNT_W | Samples skipped after the trigger |
| total_i | input | CNT_W | Samples recorded per capture (0 treated as 1) |
| adc_data_i | input | DATA_W | Offset-binary ADC sample |
| adc_ovr_i | input | 1 | ADC overrange flag |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | CNT_W | Buffer write address |
| wr_data_o | output | DATA_W+1 | Overrange flag above sample data |
| armed_o | output | 1 | Waiting for trigger |
| capturing_o | output | 1 | Samples being recorded |
| done_o | output | 1 | Capture finished |

## Verification
The bench builds the block with DATA_W = 10 and CNT_W = 8. With a counter width of 8, the largest offset of 255 and a 255-sample record both fit within a short run. The all-ones and zero values of the registers can therefore be exercised directly, next to random short captures in all four trigger modes. The ADC bus carries a value derived from the cycle count, so every written word shows which clock edge it was taken from.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;

  typedef enum logic [1:0] {
    TM_RISE = 2'b00,
    TM_FALL = 2'b01,
    TM_HIGH = 2'b10,
    TM_LOW  = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SKIP,
    ST_REC
  } seq_state_e;

  // Trigger condition from the synchronised level and its previous value.
  function automatic logic trig_match(input trig_mode_e mode,
                                      input logic cur,
                                      input logic prev);
    case (mode)
      TM_RISE: return cur & ~prev;
      TM_FALL: return ~cur & prev;
      TM_HIGH: return cur;
      default: return ~cur;
    endcase
  endfunction

endpackage

// File: rtl/cap_trig_detect.sv
module cap_trig_detect
  import cap_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_i,
  input  logic [1:0] mode_i,
  output logic       hit_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[TOP-1:0], trig_i};
      hist_q <= sync_q[TOP];
    end
  end

  assign hit_o = trig_match(trig_mode_e'(mode_i), sync_q[TOP], hist_q);

endmodule

// File: rtl/cap_sample_reg.sv
module cap_sample_reg #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ovr_i,
  output logic [DATA_W:0]   word_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_o <= '0;
    else        word_o <= {ovr_i, data_i};
  end

endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_seq_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [1:0]        trig_mode_i,
  input  logic              trig_i,
  input  logic [CNT_W-1:0]  offset_i,
  input  logic [CNT_W-1:0]  total_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic              adc_ovr_i,
  output logic              wr_en_o,
  output logic [CNT_W-1:0]  wr_addr_o,
  output logic [DATA_W:0]   wr_data_o,
  output logic              armed_o,
  output logic              capturing_o,
  output logic              done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Index of the last record word; a zero length is clamped to one word.
  function automatic logic [CNT_W-1:0] rec_last(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - ONE;
  endfunction

  seq_state_e       state;
  logic [CNT_W-1:0] skip_cnt;
  logic [CNT_W-1:0] rec_idx;
  logic [CNT_W-1:0] last_idx;
  logic             done_q;
  logic             hit;

  // Named internal events
  logic arm_accept;
  logic trig_fire;
  logic skip_end;
  logic rec_final;

  cap_trig_detect #(.SYNC_STAGES(2)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .mode_i (trig_mode_i),
    .hit_o  (hit)
  );

  cap_sample_reg #(.DATA_W(DATA_W)) u_samp (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_i (adc_data_i),
    .ovr_i  (adc_ovr_i),
    .word_o (wr_data_o)
  );

  assign arm_accept = arm_i && (state == ST_IDLE || state == ST_ARMED);
  assign trig_fire  = (state == ST_ARMED) && hit;
  assign skip_end   = (state == ST_SKIP) && (skip_cnt == ONE);
  assign rec_final  = (state == ST_REC) && (rec_idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      skip_cnt <= '0;
      rec_idx  <= '0;
      last_idx <= '0;
      done_q   <= 1'b0;
    end else begin
      if (arm_accept)     done_q <= 1'b0;
      else if (rec_final) done_q <= 1'b1;

      case (state)
        ST_IDLE: begin
          if (arm_i) state <= ST_ARMED;
        end
        ST_ARMED: begin
          if (trig_fire) begin
            last_idx <= rec_last(total_i);
            rec_idx  <= '0;
            if (offset_i == '0) begin
              state <= ST_REC;
            end else begin
              state    <= ST_SKIP;
              skip_cnt <= offset_i;
            end
          end
        end
        ST_SKIP: begin
          if (skip_end) state <= ST_REC;
          else          skip_cnt <= skip_cnt - ONE;
        end
        default: begin
          if (rec_final) state <= ST_IDLE;
          else           rec_idx <= rec_idx + ONE;
        end
      endcase
    end
  end

  assign wr_en_o     = (state == ST_REC);
  assign wr_addr_o   = rec_idx;
  assign capturing_o = (state == ST_REC);
  assign armed_o     = (state == ST_ARMED);
  assign done_o      = done_q;

endmodule

// File: rtl/cap_seq_chk.sv
module cap_seq_chk #(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_i,
  input logic [DATA_W-1:0] adc_data_i,
  input logic              adc_ovr_i,
  input logic              wr_en_o,
  input logic [CNT_W-1:0]  wr_addr_o,
  input logic [DATA_W:0]   wr_data_o,
  input logic              armed_o,
  input logic              capturing_o,
  input logic              done_o
);

  p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed_o && capturing_o));

  p_addr_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en_o) |-> wr_addr_o == '0);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(wr_en_o)) |-> wr_addr_o == $past(wr_addr_o) + CNT_W'(1));

  p_data_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_data_o == $past({adc_ovr_i, adc_data_i}));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !arm_i) |=> done_o);

  p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(wr_en_o));

  p_arm_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |-> !done_o);

  p_arm_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing_o && arm_i) |=> !armed_o);

endmodule

bind cap_seq cap_seq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm_i       (arm_i),
  .adc_data_i  (adc_data_i),
  .adc_ovr_i   (adc_ovr_i),
  .wr_en_o     (wr_en_o),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .armed_o     (armed_o),
  .capturing_o (capturing_o),
  .done_o      (done_o)
);

// File: tb/sim_cap_seq.sv
module sim_cap_seq;

  localparam int DW = 10;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          arm;
  logic [1:0]    mode;
  logic          trig;
  logic [CW-1:0] offset;
  logic [CW-1:0] total;
  logic [DW-1:0] adc_d;
  logic          adc_ovr;
  logic          wr_en;
  logic [CW-1:0] wr_addr;
  logic [DW:0]   wr_data;
  logic          armed;
  logic          capturing;
  logic          done;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cap_seq #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .trig_mode_i(mode), .trig_i(trig),
    .offset_i(offset), .total_i(total), .adc_data_i(adc_d), .adc_ovr_i(adc_ovr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .armed_o(armed), .capturing_o(capturing), .done_o(done)
  );

  // ADC word presented after posedge number c
  function automatic logic [DW:0] gval(input int c);
    return 11'((c * 37 + 5) % 2048);
  endfunction

  always @(negedge clk) {adc_ovr, adc_d} <= gval(cyc);

  function automatic logic idle_lvl(input logic [1:0] m);
    return (m == 2'b01 || m == 2'b11);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic run_capture(input logic [1:0] m, input int n, input int len,
                             input int gap, input bit poke);
    int c0, first, last, eff;
    mode   = m;
    offset = CW'(n);
    total  = CW'(len);
    trig   = idle_lvl(m);
    repeat (4) step();
    arm = 1'b1;
    step();
    arm = 1'b0;
    chk("R2", "armed after arm", 32'(armed), 1);
    chk("R2", "done cleared by arm", 32'(done), 0);
    for (int g = 0; g < gap; g++) begin
      step();
      chk("R2", "still armed without trigger", 32'(armed), 1);
      chk("R2", "no write without trigger", 32'(wr_en), 0);
    end
    step();
    c0   = cyc;
    trig = ~idle_lvl(m);
    eff   = (len == 0) ? 1 : len;
    first = c0 + 3 + n;
    last  = first + eff - 1;
    while (cyc < last + 2) begin
      step();
      if (arm) arm = 1'b0;
      begin
        int e = cyc;
        bit en = (e >= first) && (e <= last);
        chk("R4", "write enable timing", 32'(wr_en), 32'(en));
        chk("R10", "capturing indicator", 32'(capturing), 32'(en));
        chk("R3", "armed until trigger acted on", 32'(armed), 32'(e < c0 + 3));
        chk("R7", "done timing", 32'(done), 32'(e > last));
        if (en) begin
          chk("R5", "write address", 32'(wr_addr), 32'(e - first));
          chk("R6", "write data", 32'(wr_data), 32'(gval(e - 1)));
        end
        if (poke && e == c0 + 3) begin
          total  = total ^ 8'h55;   // R9: late change must not matter
          offset = offset ^ 8'h0F;
        end
        if (poke && e == first) arm = 1'b1;  // R8: arm while recording
      end
    end
    chk("R8", "idle after capture", 32'(armed), 0);
    trig = idle_lvl(m);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; arm = 1'b0; mode = 2'b00; trig = 1'b0;
    offset = '0; total = '0;
    repeat (3) step();
    chk("R1", "armed in reset", 32'(armed), 0);
    chk("R1", "done in reset", 32'(done), 0);
    rst_n = 1'b1;
    step();
    chk("R1", "wr_en after reset", 32'(wr_en), 0);
    chk("R1", "capturing after reset", 32'(capturing), 0);
    chk("R1", "done after reset", 32'(done), 0);

    // R11: rising mode with trigger already high must not fire
    mode = 2'b00; trig = 1'b1;
    repeat (5) step();
    arm = 1'b1; step(); arm = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step();
      chk("R11", "stale high level ignored", 32'(armed), 1);
      chk("R11", "no write on stale level", 32'(wr_en), 0);
    end
    trig = 1'b0;
    repeat (3) step();
    chk("R11", "still armed after fall", 32'(armed), 1);
    run_capture(2'b00, 2, 4, 0, 1'b0);

    // Directed corners
    run_capture(2'b00, 0, 0, 1, 1'b0);     // R4/R5 zero offset, zero length
    run_capture(2'b01, 255, 3, 0, 1'b0);   // R4 largest offset
    run_capture(2'b10, 1, 255, 2, 1'b0);   // R5 longest record
    run_capture(2'b11, 3, 6, 1, 1'b1);     // R8/R9 arm and register change mid-capture
    run_capture(2'b10, 0, 1, 0, 1'b1);     // R8 single-word record

    // Constrained random captures
    for (int k = 0; k < 24; k++) begin
      run_capture(2'($urandom % 4), int'($urandom % 8), int'($urandom % 12),
                  int'($urandom % 5), bit'($urandom % 2));
    end

    summary();
    $finish;
  end

endmodule